// File: doc/BRIEF.md
# Instruction-Indexed Data Prefetcher

This block watches the stream of load accesses, each tagged with the instruction pointer (IP) of the load that made it, and learns per load instruction how that instruction walks through memory. Each table slot learns two kinds of behaviour. The first is a constant signed byte stride between successive addresses. The second is a footprint: the set of 64-byte lines that the instruction touched inside an aligned 1 KB region, kept as the pattern to replay once the instruction moves on to a new region.

A separate trigger port reports data-cache misses together with the IP and address of the missing load. If the missing instruction has a trained slot, the block issues prefetch line addresses on a valid/ready request port. It issues one request for a confident stride. Otherwise it issues a cluster of footprint lines in the region of the miss. Every request carries a flag that tells stride requests from footprint requests, so a downstream merger can combine this source with another prefetcher.

Top module: `ipf_prefetcher`

## Requirements
- R1: After a synchronous active-low reset, `pf_valid` is low and every table slot is empty, so a miss from any IP produces no request.
- R2: A slot is selected by the low 4 bits of the IP and tagged with the remaining IP bits. An observation whose tag differs from the stored one replaces the slot and clears its stride, confidence and both footprints.
- R3: On each tag-matching observation, the difference from the stored last address is compared with the stored stride. A match raises the 2-bit confidence, saturating at 3. A mismatch lowers it by one. A mismatch at confidence 0 replaces the stride with the new difference.
- R4: Strides are signed byte distances of 16 bits, so negative strides and positive strides up to 32704 bytes (511 lines) are learned.
- R5: A difference that does not fit the 16-bit signed stride counts as a mismatch. When it lands at confidence 0, the stride becomes zero, and a zero stride never produces a request.
- R6: A stride request is issued only when the slot's confidence is 3 and its stride is nonzero. After one mismatching observation the slot stops producing stride requests.
- R7: A stride request has the address line-align(miss address + stride) with `pf_region` = 0. It takes priority over the footprint, and a trigger produces only this one request.
- R8: When an observation enters a different 1 KB region from the previous one, the lines touched in the old region become the learned footprint. A miss without stride confidence then emits region base + 64*k for every learned line k other than the missed one, in ascending k, with `pf_region` = 1.
- R9: While `pf_valid` is high and `pf_ready` is low, `pf_valid`, `pf_addr` and `pf_region` hold their values.
- R10: A miss that arrives while a request is still pending (`pf_valid` high) is dropped and never produces requests.
- R11: A miss that arrives in the same cycle as an observation of the same IP is judged on the slot state from before that observation's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| obs_valid | input | 1 | Load observation present this cycle |
| obs_ip | input | 32 | Instruction pointer of the observed load |
| obs_addr | input | 32 | Byte address of the observed load |
| miss_valid | input | 1 | Data-cache miss trigger present this cycle |
| miss_ip | input | 32 | Instruction pointer of the missing load |
| miss_addr | input | 32 | Byte address of the missing load |
| pf_ready | input | 1 | Request consumer accepts the current request |
| pf_valid | output | 1 | A prefetch request is offered |
| pf_addr | output | 32 | Line-aligned prefetch address |
| pf_region | output | 1 | 1 for a footprint request, 0 for a stride request |

## Verification
Training and triggering can land in the same cycle on the same slot: a load observation updates a slot while a miss from the same IP reads it. The bench provokes this with an IP held at confidence 2 and one cycle that carries both its confirming observation and its miss. The judgement is that no request appears, because the lookup sees the older confidence. A miss alone on the next cycle must then yield the stride request. A second collision, a trigger arriving while a footprint cluster is held back by `pf_ready`, is judged by counting the requests that come out once the consumer accepts again.

// File: rtl/ipf_pkg.sv
// Package: shared types for the instruction-indexed prefetcher.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable subset.
package ipf_pkg;

    // Source kind of a request, reported to a downstream merger.
    typedef enum logic {
        PF_STRIDE = 1'b0,
        PF_REGION = 1'b1
    } pf_kind_e;

    // Default geometry shared by the modules.
    localparam int DEF_IP_W         = 32;
    localparam int DEF_ADDR_W       = 32;
    localparam int DEF_ENTRIES      = 16;
    localparam int DEF_LINE_BYTES   = 64;
    localparam int DEF_REGION_LINES = 16;
    localparam int DEF_STRIDE_W     = 16;
    localparam int DEF_CONF_W       = 2;

endpackage

// File: rtl/ipf_table.sv
// Module: per-instruction training table.
// Does: direct-mapped storage, indexed by the low IP bits and tagged by the rest.
//       Learns a signed stride with a saturating confidence counter, plus a
//       footprint of the lines touched in the current region and in the previous one.
//       Provides a read port that shows the state from before this cycle's write.
// Assumes: ENTRIES and REGION_LINES are powers of two, and STRIDE_W < ADDR_W.
module ipf_table #(
    parameter int IP_W         = ipf_pkg::DEF_IP_W,
    parameter int ADDR_W       = ipf_pkg::DEF_ADDR_W,
    parameter int ENTRIES      = ipf_pkg::DEF_ENTRIES,
    parameter int LINE_BYTES   = ipf_pkg::DEF_LINE_BYTES,
    parameter int REGION_LINES = ipf_pkg::DEF_REGION_LINES,
    parameter int STRIDE_W     = ipf_pkg::DEF_STRIDE_W,
    parameter int CONF_W       = ipf_pkg::DEF_CONF_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    obs_valid,
    input  logic [IP_W-1:0]         obs_ip,
    input  logic [ADDR_W-1:0]       obs_addr,
    input  logic [IP_W-1:0]         rd_ip,
    output logic                    rd_hit,
    output logic [STRIDE_W-1:0]     rd_stride,
    output logic [CONF_W-1:0]       rd_conf,
    output logic [REGION_LINES-1:0] rd_map
);
    localparam int IDX_W  = $clog2(ENTRIES);
    localparam int TAG_W  = IP_W - IDX_W;
    localparam int LINE_B = $clog2(LINE_BYTES);
    localparam int OFF_W  = $clog2(REGION_LINES);
    localparam int REG_B  = LINE_B + OFF_W;
    localparam logic [CONF_W-1:0] CONF_MAX = '1;

    logic [ENTRIES-1:0]      valid_q;
    logic [TAG_W-1:0]        tag_q    [ENTRIES];
    logic [ADDR_W-1:0]       last_q   [ENTRIES];
    logic [STRIDE_W-1:0]     stride_q [ENTRIES];
    logic [CONF_W-1:0]       conf_q   [ENTRIES];
    logic [REGION_LINES-1:0] cur_q    [ENTRIES];
    logic [REGION_LINES-1:0] old_q    [ENTRIES];

    logic [IDX_W-1:0]        w_idx;
    logic [TAG_W-1:0]        w_tag;
    logic                    w_hit;
    logic [OFF_W-1:0]        w_off;
    logic [REGION_LINES-1:0] w_bit;
    logic [ADDR_W-1:0]       w_delta;
    logic                    w_in_rng;
    logic                    w_same_stride;
    logic                    w_same_region;
    logic [CONF_W-1:0]       w_conf_cur;

    logic [STRIDE_W-1:0]     n_stride;
    logic [CONF_W-1:0]       n_conf;
    logic [REGION_LINES-1:0] n_cur;
    logic [REGION_LINES-1:0] n_old;

    logic [IDX_W-1:0]        r_idx;
    logic [TAG_W-1:0]        r_tag;

    // Decode the observation into slot, tag and line offset.
    assign w_idx      = obs_ip[IDX_W-1:0];
    assign w_tag      = obs_ip[IP_W-1:IDX_W];
    assign w_hit      = valid_q[w_idx] && (tag_q[w_idx] == w_tag);
    assign w_off      = obs_addr[REG_B-1:LINE_B];
    assign w_bit      = REGION_LINES'(1) << w_off;
    assign w_conf_cur = conf_q[w_idx];

    // Compare the new address with the slot's history.
    assign w_delta       = obs_addr - last_q[w_idx];
    assign w_in_rng      = (&w_delta[ADDR_W-1:STRIDE_W-1]) || !(|w_delta[ADDR_W-1:STRIDE_W-1]);
    assign w_same_stride = w_in_rng && (w_delta[STRIDE_W-1:0] == stride_q[w_idx]);
    assign w_same_region = (obs_addr[ADDR_W-1:REG_B] == last_q[w_idx][ADDR_W-1:REG_B]);

    // Next stride, confidence and footprints for the observed slot.
    always_comb begin : train_next
        n_stride = stride_q[w_idx];
        n_conf   = w_conf_cur;
        n_cur    = cur_q[w_idx];
        n_old    = old_q[w_idx];
        if (!w_hit) begin
            n_stride = '0;
            n_conf   = '0;
            n_cur    = w_bit;
            n_old    = '0;
        end else begin
            if (w_same_stride) begin
                if (w_conf_cur != CONF_MAX) begin
                    n_conf = w_conf_cur + CONF_W'(1);
                end
            end else if (w_conf_cur != '0) begin
                n_conf = w_conf_cur - CONF_W'(1);
            end else begin
                n_stride = w_in_rng ? w_delta[STRIDE_W-1:0] : '0;
            end
            if (w_same_region) begin
                n_cur = cur_q[w_idx] | w_bit;
            end else begin
                n_old = cur_q[w_idx];
                n_cur = w_bit;
            end
        end
    end

    // Write the observed slot, or clear the whole table on reset.
    always_ff @(posedge clk) begin : table_write
        if (!rst_n) begin
            valid_q <= '0;
            for (int e = 0; e < ENTRIES; e++) begin
                tag_q[e]    <= '0;
                last_q[e]   <= '0;
                stride_q[e] <= '0;
                conf_q[e]   <= '0;
                cur_q[e]    <= '0;
                old_q[e]    <= '0;
            end
        end else if (obs_valid) begin
            valid_q[w_idx]  <= 1'b1;
            tag_q[w_idx]    <= w_tag;
            last_q[w_idx]   <= obs_addr;
            stride_q[w_idx] <= n_stride;
            conf_q[w_idx]   <= n_conf;
            cur_q[w_idx]    <= n_cur;
            old_q[w_idx]    <= n_old;
        end
    end

    // Lookup port for the trigger path: shows the registered state only.
    assign r_idx     = rd_ip[IDX_W-1:0];
    assign r_tag     = rd_ip[IP_W-1:IDX_W];
    assign rd_hit    = valid_q[r_idx] && (tag_q[r_idx] == r_tag);
    assign rd_stride = stride_q[r_idx];
    assign rd_conf   = conf_q[r_idx];
    assign rd_map    = old_q[r_idx];

    // R2: an observation always leaves its slot valid.
    assert_slot_filled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        obs_valid |=> valid_q[$past(w_idx)]);

    // R3: confidence moves by at most one step for each observation.
    assert_conf_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (obs_valid && w_hit) |=>
            ((conf_q[$past(w_idx)] == $past(w_conf_cur)) ||
             (conf_q[$past(w_idx)] == $past(w_conf_cur) + CONF_W'(1)) ||
             (conf_q[$past(w_idx)] == $past(w_conf_cur) - CONF_W'(1))));

endmodule

// File: rtl/ipf_decide.sv
// Module: trigger decision.
// Does: from the looked-up slot and the miss address, chooses stride or footprint
//       mode and forms the stride target, the region base and the line mask.
// Assumes: purely combinational; stride mode has priority over the footprint.
module ipf_decide #(
    parameter int ADDR_W       = ipf_pkg::DEF_ADDR_W,
    parameter int LINE_BYTES   = ipf_pkg::DEF_LINE_BYTES,
    parameter int REGION_LINES = ipf_pkg::DEF_REGION_LINES,
    parameter int STRIDE_W     = ipf_pkg::DEF_STRIDE_W,
    parameter int CONF_W       = ipf_pkg::DEF_CONF_W
) (
    input  logic                    rd_hit,
    input  logic [STRIDE_W-1:0]     rd_stride,
    input  logic [CONF_W-1:0]       rd_conf,
    input  logic [REGION_LINES-1:0] rd_map,
    input  logic [ADDR_W-1:0]       miss_addr,
    output logic                    want_stride,
    output logic                    want_region,
    output logic [ADDR_W-1:0]       stride_addr,
    output logic [ADDR_W-1:0]       region_base,
    output logic [REGION_LINES-1:0] region_mask
);
    localparam int LINE_B = $clog2(LINE_BYTES);
    localparam int OFF_W  = $clog2(REGION_LINES);
    localparam int REG_B  = LINE_B + OFF_W;
    localparam logic [CONF_W-1:0] CONF_MAX  = '1;
    localparam logic [ADDR_W-1:0] LINE_MASK = ~(ADDR_W'(LINE_BYTES - 1));
    localparam logic [ADDR_W-1:0] REG_MASK  = ~(ADDR_W'((1 << REG_B) - 1));

    logic [ADDR_W-1:0]       stride_ext;
    logic [OFF_W-1:0]        miss_off;

    // Sign-extend the stride and add it to the missing address.
    assign stride_ext  = {{(ADDR_W-STRIDE_W){rd_stride[STRIDE_W-1]}}, rd_stride};
    assign stride_addr = (miss_addr + stride_ext) & LINE_MASK;

    // Footprint lines in the missing region, minus the line that missed.
    assign miss_off    = miss_addr[REG_B-1:LINE_B];
    assign region_base = miss_addr & REG_MASK;
    assign region_mask = rd_map & ~(REGION_LINES'(1) << miss_off);

    // Mode choice: a confident nonzero stride wins, else a nonempty footprint.
    assign want_stride = rd_hit && (rd_conf == CONF_MAX) && (rd_stride != '0);
    assign want_region = rd_hit && !want_stride && (region_mask != '0);

endmodule

// File: rtl/ipf_issue.sv
// Module: request issue engine.
// Does: loads one request (stride) or a line mask (footprint) on an accepted
//       trigger and offers the lines one per cycle, lowest offset first, under
//       valid/ready flow control.
// Assumes: a trigger is accepted only while nothing is pending.
module ipf_issue #(
    parameter int ADDR_W       = ipf_pkg::DEF_ADDR_W,
    parameter int LINE_BYTES   = ipf_pkg::DEF_LINE_BYTES,
    parameter int REGION_LINES = ipf_pkg::DEF_REGION_LINES
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    miss_valid,
    input  logic                    want_stride,
    input  logic                    want_region,
    input  logic [ADDR_W-1:0]       stride_addr,
    input  logic [ADDR_W-1:0]       region_base,
    input  logic [REGION_LINES-1:0] region_mask,
    input  logic                    pf_ready,
    output logic                    pf_valid,
    output logic [ADDR_W-1:0]       pf_addr,
    output logic                    pf_region
);
    import ipf_pkg::*;

    localparam int LINE_B = $clog2(LINE_BYTES);
    localparam int OFF_W  = $clog2(REGION_LINES);

    logic                    busy_q;
    logic [ADDR_W-1:0]       addr_q;
    logic [ADDR_W-1:0]       base_q;
    logic [REGION_LINES-1:0] rem_q;
    pf_kind_e                kind_q;

    logic [OFF_W-1:0]        first_off;
    logic [OFF_W-1:0]        next_off;
    logic                    accept;
    logic                    fire;

    // Lowest set line of the incoming footprint mask.
    always_comb begin : pick_first
        first_off = '0;
        for (int i = REGION_LINES - 1; i >= 0; i--) begin
            if (region_mask[i]) first_off = OFF_W'(i);
        end
    end

    // Lowest set line still waiting in the current cluster.
    always_comb begin : pick_next
        next_off = '0;
        for (int i = REGION_LINES - 1; i >= 0; i--) begin
            if (rem_q[i]) next_off = OFF_W'(i);
        end
    end

    assign accept = !busy_q && miss_valid && (want_stride || want_region);
    assign fire   = busy_q && pf_ready;

    // Load a new request set, or step through the cluster on each handshake.
    always_ff @(posedge clk) begin : issue_seq
        if (!rst_n) begin
            busy_q <= 1'b0;
            addr_q <= '0;
            base_q <= '0;
            rem_q  <= '0;
            kind_q <= PF_STRIDE;
        end else if (accept) begin
            busy_q <= 1'b1;
            if (want_stride) begin
                addr_q <= stride_addr;
                rem_q  <= '0;
                kind_q <= PF_STRIDE;
            end else begin
                addr_q <= region_base | (ADDR_W'(first_off) << LINE_B);
                base_q <= region_base;
                rem_q  <= region_mask & ~(REGION_LINES'(1) << first_off);
                kind_q <= PF_REGION;
            end
        end else if (fire) begin
            if (rem_q != '0) begin
                addr_q <= base_q | (ADDR_W'(next_off) << LINE_B);
                rem_q  <= rem_q & ~(REGION_LINES'(1) << next_off);
            end else begin
                busy_q <= 1'b0;
            end
        end
    end

    assign pf_valid  = busy_q;
    assign pf_addr   = addr_q;
    assign pf_region = (kind_q == PF_REGION);

    // R9: an unaccepted request holds steady.
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_addr) && $stable(pf_region)));

    // R8: footprint lines come out in ascending address order.
    assert_ascend_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && (kind_q == PF_REGION) && (rem_q != '0)) |=> (pf_addr > $past(pf_addr)));

    // R10: a new request set only ever starts from a trigger.
    assert_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pf_valid) |-> $past(miss_valid));

endmodule

// File: rtl/ipf_prefetcher.sv
// Module: instruction-indexed data prefetcher, top level.
// Does: trains a per-IP table from load observations and, on a miss trigger,
//       issues stride or footprint prefetch lines on a valid/ready port.
// Assumes: observations and triggers each come at most one per cycle; a trigger
//          sees the table as it stood before that cycle's observation.
module ipf_prefetcher #(
    parameter int IP_W         = ipf_pkg::DEF_IP_W,
    parameter int ADDR_W       = ipf_pkg::DEF_ADDR_W,
    parameter int ENTRIES      = ipf_pkg::DEF_ENTRIES,
    parameter int LINE_BYTES   = ipf_pkg::DEF_LINE_BYTES,
    parameter int REGION_LINES = ipf_pkg::DEF_REGION_LINES,
    parameter int STRIDE_W     = ipf_pkg::DEF_STRIDE_W,
    parameter int CONF_W       = ipf_pkg::DEF_CONF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              obs_valid,
    input  logic [IP_W-1:0]   obs_ip,
    input  logic [ADDR_W-1:0] obs_addr,
    input  logic              miss_valid,
    input  logic [IP_W-1:0]   miss_ip,
    input  logic [ADDR_W-1:0] miss_addr,
    input  logic              pf_ready,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_addr,
    output logic              pf_region
);
    logic                    rd_hit;
    logic [STRIDE_W-1:0]     rd_stride;
    logic [CONF_W-1:0]       rd_conf;
    logic [REGION_LINES-1:0] rd_map;
    logic                    want_stride;
    logic                    want_region;
    logic [ADDR_W-1:0]       stride_addr;
    logic [ADDR_W-1:0]       region_base;
    logic [REGION_LINES-1:0] region_mask;

    ipf_table #(
        .IP_W(IP_W), .ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .LINE_BYTES(LINE_BYTES),
        .REGION_LINES(REGION_LINES), .STRIDE_W(STRIDE_W), .CONF_W(CONF_W)
    ) i_table (
        .clk(clk), .rst_n(rst_n),
        .obs_valid(obs_valid), .obs_ip(obs_ip), .obs_addr(obs_addr),
        .rd_ip(miss_ip),
        .rd_hit(rd_hit), .rd_stride(rd_stride), .rd_conf(rd_conf), .rd_map(rd_map)
    );

    ipf_decide #(
        .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .REGION_LINES(REGION_LINES),
        .STRIDE_W(STRIDE_W), .CONF_W(CONF_W)
    ) i_decide (
        .rd_hit(rd_hit), .rd_stride(rd_stride), .rd_conf(rd_conf), .rd_map(rd_map),
        .miss_addr(miss_addr),
        .want_stride(want_stride), .want_region(want_region),
        .stride_addr(stride_addr), .region_base(region_base), .region_mask(region_mask)
    );

    ipf_issue #(
        .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .REGION_LINES(REGION_LINES)
    ) i_issue (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid),
        .want_stride(want_stride), .want_region(want_region),
        .stride_addr(stride_addr), .region_base(region_base), .region_mask(region_mask),
        .pf_ready(pf_ready), .pf_valid(pf_valid), .pf_addr(pf_addr), .pf_region(pf_region)
    );

    // R7: a stride request always comes from a slot that was confident.
    assert_stride_conf_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pf_valid) && !pf_region) |-> ($past(rd_conf) == '1));

endmodule

// File: tb/test_ipf_prefetcher.sv
// Directed bench for the instruction-indexed prefetcher: one task per scenario.
module test_ipf_prefetcher;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        obs_valid = 1'b0;
    logic [31:0] obs_ip = '0;
    logic [31:0] obs_addr = '0;
    logic        miss_valid = 1'b0;
    logic [31:0] miss_ip = '0;
    logic [31:0] miss_addr = '0;
    logic        pf_ready = 1'b0;
    logic        pf_valid;
    logic [31:0] pf_addr;
    logic        pf_region;

    int          n_tests = 0;
    int          n_fail  = 0;
    logic [31:0] got_addr [8];
    logic        got_reg  [8];
    int          n_got = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ipf_prefetcher i_ipf_prefetcher (
        .clk(clk), .rst_n(rst_n),
        .obs_valid(obs_valid), .obs_ip(obs_ip), .obs_addr(obs_addr),
        .miss_valid(miss_valid), .miss_ip(miss_ip), .miss_addr(miss_addr),
        .pf_ready(pf_ready), .pf_valid(pf_valid), .pf_addr(pf_addr), .pf_region(pf_region)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; obs_valid = 1'b0; miss_valid = 1'b0; pf_ready = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic observe(input logic [31:0] ip, input logic [31:0] addr);
        obs_valid = 1'b1; obs_ip = ip; obs_addr = addr;
        @(posedge clk); @(negedge clk);
        obs_valid = 1'b0;
    endtask

    task automatic trigger(input logic [31:0] ip, input logic [31:0] addr);
        miss_valid = 1'b1; miss_ip = ip; miss_addr = addr;
        @(posedge clk); @(negedge clk);
        miss_valid = 1'b0;
    endtask

    task automatic observe_and_trigger(input logic [31:0] ip, input logic [31:0] addr);
        obs_valid = 1'b1; obs_ip = ip; obs_addr = addr;
        miss_valid = 1'b1; miss_ip = ip; miss_addr = addr;
        @(posedge clk); @(negedge clk);
        obs_valid = 1'b0; miss_valid = 1'b0;
    endtask

    // Accept requests for a number of cycles and record them.
    task automatic collect(input int cycles);
        n_got = 0;
        pf_ready = 1'b1;
        for (int c = 0; c < cycles; c++) begin
            if (pf_valid && n_got < 8) begin
                got_addr[n_got] = pf_addr;
                got_reg[n_got]  = pf_region;
                n_got++;
            end
            @(posedge clk); @(negedge clk);
        end
        pf_ready = 1'b0;
    endtask

    task automatic test_reset();
        do_reset();
        chk(pf_valid == 1'b0, "R1", "pf_valid after reset", 32'(pf_valid), 32'h0);
        trigger(32'h0000_0123, 32'h0000_5000);
        collect(4);
        chk(n_got == 0, "R1", "requests from empty table", 32'(n_got), 32'h0);
    endtask

    task automatic test_stride_confidence();
        do_reset();
        observe(32'h100, 32'h1000);
        observe(32'h100, 32'h1040);
        observe(32'h100, 32'h1080);
        observe(32'h100, 32'h10C0);
        trigger(32'h100, 32'h1100);
        collect(4);
        chk(n_got == 0, "R6", "no request at confidence 2", 32'(n_got), 32'h0);
        observe(32'h100, 32'h1100);
        trigger(32'h100, 32'h1140);
        collect(4);
        chk(n_got == 1, "R3", "one stride request at confidence 3", 32'(n_got), 32'h1);
        chk(got_addr[0] == 32'h1180, "R7", "stride target", got_addr[0], 32'h1180);
        chk(got_reg[0] == 1'b0, "R7", "stride flag", 32'(got_reg[0]), 32'h0);
        do_reset();
        trigger(32'h100, 32'h1180);
        collect(4);
        chk(n_got == 0, "R1", "reset forgets trained slot", 32'(n_got), 32'h0);
    endtask

    task automatic test_wide_strides();
        do_reset();
        observe(32'h201, 32'h80000);
        observe(32'h201, 32'h7F000);
        observe(32'h201, 32'h7E000);
        observe(32'h201, 32'h7D000);
        observe(32'h201, 32'h7C000);
        trigger(32'h201, 32'h7C010);
        collect(4);
        chk(n_got == 1, "R4", "negative stride request count", 32'(n_got), 32'h1);
        chk(got_addr[0] == 32'h7B000, "R4", "negative stride target", got_addr[0], 32'h7B000);
        do_reset();
        observe(32'h302, 32'h00000);
        observe(32'h302, 32'h07FC0);
        observe(32'h302, 32'h0FF80);
        observe(32'h302, 32'h17F40);
        observe(32'h302, 32'h1FF00);
        trigger(32'h302, 32'h20000);
        collect(4);
        chk(n_got == 1, "R7", "stride beats footprint, one request", 32'(n_got), 32'h1);
        chk(got_addr[0] == 32'h27FC0, "R4", "large stride target", got_addr[0], 32'h27FC0);
        chk(got_reg[0] == 1'b0, "R7", "stride flag with footprint present", 32'(got_reg[0]), 32'h0);
    endtask

    task automatic test_out_of_range();
        do_reset();
        observe(32'h403, 32'h00000);
        observe(32'h403, 32'h10000);
        observe(32'h403, 32'h20000);
        observe(32'h403, 32'h30000);
        observe(32'h403, 32'h40000);
        observe(32'h403, 32'h50000);
        trigger(32'h403, 32'h50000);
        collect(4);
        chk(n_got == 0, "R5", "oversized delta yields no stride", 32'(n_got), 32'h0);
    endtask

    task automatic test_mismatch();
        do_reset();
        observe(32'h504, 32'h2000);
        observe(32'h504, 32'h2040);
        observe(32'h504, 32'h2080);
        observe(32'h504, 32'h20C0);
        observe(32'h504, 32'h2100);
        observe(32'h504, 32'h2300);
        trigger(32'h504, 32'h2340);
        collect(4);
        chk(n_got == 0, "R6", "one mismatch stops stride requests", 32'(n_got), 32'h0);
    endtask

    task automatic test_region_backpressure();
        do_reset();
        observe(32'h605, 32'h4040);
        observe(32'h605, 32'h40C0);
        observe(32'h605, 32'h4180);
        observe(32'h605, 32'h80C0);
        trigger(32'h605, 32'h80C0);
        for (int c = 0; c < 3; c++) begin
            chk(pf_valid == 1'b1, "R9", "valid held under backpressure", 32'(pf_valid), 32'h1);
            chk(pf_addr == 32'h8040, "R9", "address held under backpressure", pf_addr, 32'h8040);
            if (c == 1) begin
                trigger(32'h605, 32'hC000);
            end else begin
                @(posedge clk); @(negedge clk);
            end
        end
        collect(8);
        chk(n_got == 2, "R10", "busy-time trigger dropped", 32'(n_got), 32'h2);
        chk(got_addr[0] == 32'h8040, "R8", "first footprint line", got_addr[0], 32'h8040);
        chk(got_addr[1] == 32'h8180, "R8", "second footprint line, missed line skipped",
            got_addr[1], 32'h8180);
        chk(got_reg[0] == 1'b1 && got_reg[1] == 1'b1, "R8", "footprint flag",
            32'({got_reg[0], got_reg[1]}), 32'h3);
        chk(pf_valid == 1'b0, "R10", "idle after cluster", 32'(pf_valid), 32'h0);
    endtask

    task automatic test_alias();
        do_reset();
        observe(32'h706, 32'h6000);
        observe(32'h706, 32'h6040);
        observe(32'h706, 32'h6080);
        observe(32'h706, 32'h60C0);
        observe(32'h706, 32'h6100);
        trigger(32'h706, 32'h6140);
        collect(4);
        chk(n_got == 1 && got_addr[0] == 32'h6180, "R2", "trained slot before alias",
            got_addr[0], 32'h6180);
        observe(32'h716, 32'h9000);
        trigger(32'h706, 32'h6140);
        collect(4);
        chk(n_got == 0, "R2", "aliasing IP evicts slot", 32'(n_got), 32'h0);
        observe(32'h706, 32'h6140);
        trigger(32'h706, 32'h6180);
        collect(4);
        chk(n_got == 0, "R2", "reallocated slot starts clear", 32'(n_got), 32'h0);
    endtask

    task automatic test_same_cycle();
        do_reset();
        observe(32'h808, 32'hA000);
        observe(32'h808, 32'hA040);
        observe(32'h808, 32'hA080);
        observe(32'h808, 32'hA0C0);
        observe_and_trigger(32'h808, 32'hA100);
        collect(4);
        chk(n_got == 0, "R11", "trigger sees pre-update confidence", 32'(n_got), 32'h0);
        trigger(32'h808, 32'hA100);
        collect(4);
        chk(n_got == 1 && got_addr[0] == 32'hA140, "R11", "next trigger sees update",
            got_addr[0], 32'hA140);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        test_reset();
        test_stride_confidence();
        test_wide_strides();
        test_out_of_range();
        test_mismatch();
        test_region_backpressure();
        test_alias();
        test_same_cycle();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule